// File: doc/BRIEF.md
# Oversampling Serial Receiver with Break Detection

This block receives asynchronous serial characters from a single input line. A tick at sixteen times the baud rate paces it. The receiver waits for a falling edge. It confirms the start bit halfway through the bit time, then samples each data bit at its centre, least significant bit first. A pin selects eight or nine data bits per character. The stop bit is sampled the same way. The received byte goes to a data output and the extra bit of a nine-bit character goes to a separate output. The block reports a receive-full flag, a framing error, an overrun and a break flag. One clear strobe clears all four flags.

A character whose data bits are all zero and whose stop position also reads zero is a break. On a break the framing error, receive-full and break flags all set, and the data and ninth-bit outputs are forced to zero. After any character that ends with a low stop position, the receiver stays quiet until the line returns high. Only then does it look for a new start bit. A line held low therefore never produces more than one character.

Top module: `uart_brk_rx`

## Requirements
- R1: A start bit is accepted only if the line, after falling from 1 to 0, still reads 0 on the eighth oversampling tick after the tick that saw the fall. Otherwise the receiver goes back to hunting and reports nothing.
- R2: Data bits are sampled at bit centres, least significant first. With `nine_sel`=0 eight bits are taken and `rx_bit9` reads 0. With `nine_sel`=1 nine bits are taken and the last one appears on `rx_bit9`.
- R3: A character with a stop bit of 1 sets `rx_full`, clears `frame_err` and presents its data on `rx_data`/`rx_bit9`.
- R4: A character with a stop bit of 0 and at least one data bit at 1 sets `frame_err` and `rx_full` and leaves `brk_det` at 0. Its data is still presented.
- R5: A character with all data bits at 0 (all 8 or all 9) and a stop position of 0 is a break. It sets `brk_det`, `frame_err` and `rx_full`, and drives `rx_data` and `rx_bit9` to 0.
- R6: After a character whose stop position reads 0, no new start bit is accepted until the line has read 1. A line that stays low produces no further characters.
- R7: When a character completes while `rx_full` is still 1, `overrun` sets and `rx_data`/`rx_bit9` keep the older values. `frame_err` and `brk_det` may still set from the new character.
- R8: A one-cycle pulse on `flag_clr` clears `rx_full`, `frame_err`, `overrun` and `brk_det`. It leaves `rx_data` unchanged.
- R9: `rx_busy` is 1 from the falling edge that starts a character until its stop bit has been sampled.
- R10: While `rx_en` is 0 the receiver accepts no character and the flags hold. When `rx_en` returns to 1, the receiver first waits for the line to read 1.
- R11: After reset `rx_data`, `rx_bit9`, all flags and `rx_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_en | input | 1 | Receiver enable |
| rx_line | input | 1 | Serial input, idle high |
| tick16 | input | 1 | One-cycle pulse at sixteen times the baud rate |
| nine_sel | input | 1 | 1 selects nine data bits, 0 selects eight |
| flag_clr | input | 1 | Strobe that clears the status flags |
| rx_data | output | 8 | Received data byte |
| rx_bit9 | output | 1 | Ninth received bit (0 in eight-bit mode) |
| rx_full | output | 1 | Received character waiting |
| frame_err | output | 1 | Stop position read 0 |
| overrun | output | 1 | Character completed while the previous one was unread |
| brk_det | output | 1 | Break character received |
| rx_busy | output | 1 | Character reception in progress |

## Verification
The bench builds the receiver with its default parameters: eight base data bits and sixteen-times oversampling. It drives `tick16` once every four clocks, so one bit lasts 64 clocks. That is long enough to glitch the line shorter than the half-bit start check, and to hold the line low for many bit times after a break. Switching `nine_sel` at run time brings both frame lengths into reach. This covers breaks that need nine zeros, and the case where a nine-bit character's ninth bit alone stops it from being a break.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

  parameter int unsigned DW = 8;

  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_START = 3'd2,
    ST_DATA  = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic [DW:0] bits;
    logic        stop;
    logic        brk;
  } rx_frame_t;

endpackage

// File: rtl/uart_brk_rstsync.sv
module uart_brk_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/uart_brk_insync.sv
module uart_brk_insync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic stage_d;
    if (g == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= 1'b1;
      end else begin
        stage_q[g] <= stage_d;
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/uart_brk_ctrl.sv
module uart_brk_ctrl
  import uart_brk_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  logic      tick_i,
  input  logic      line_i,
  input  logic      nine_i,
  output logic      done_o,
  output rx_frame_t frame_o,
  output logic      busy_o
);

  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned MID = OVS / 2;
  localparam int unsigned BW  = $clog2(DW + 2);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     idx_q, idx_d;
  logic [DW:0]       shf_q, shf_d;
  logic              done_q, done_d;
  rx_frame_t         frame_q, frame_d;
  logic [BW-1:0]     last_idx;
  logic [DW:0]       frame_bits;

  assign last_idx   = nine_i ? BW'(DW) : BW'(DW - 1);
  assign frame_bits = nine_i ? shf_q : {1'b0, shf_q[DW-1:0]};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shf_d   = shf_q;
    done_d  = 1'b0;
    frame_d = frame_q;
    if (!en_i) begin
      state_d = ST_WAIT;
      cnt_d   = '0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_WAIT: begin
          if (line_i) state_d = ST_IDLE;
        end
        ST_IDLE: begin
          if (!line_i) begin
            state_d = ST_START;
            cnt_d   = '0;
          end
        end
        ST_START: begin
          if (cnt_q == CW'(MID - 1)) begin
            cnt_d = '0;
            if (!line_i) begin
              state_d = ST_DATA;
              idx_d   = '0;
              shf_d   = '0;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == CW'(OVS - 1)) begin
            cnt_d = '0;
            for (int i = 0; i <= DW; i++) begin
              if (idx_q == BW'(i)) shf_d[i] = line_i;
            end
            if (idx_q == last_idx) begin
              state_d = ST_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q == CW'(OVS - 1)) begin
            cnt_d         = '0;
            done_d        = 1'b1;
            frame_d.bits  = frame_bits;
            frame_d.stop  = line_i;
            frame_d.brk   = !line_i && (frame_bits == '0);
            state_d       = line_i ? ST_IDLE : ST_WAIT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      idx_q   <= '0;
      shf_q   <= '0;
      done_q  <= 1'b0;
      frame_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shf_q   <= shf_d;
      done_q  <= done_d;
      frame_q <= frame_d;
    end
  end

  assign done_o  = done_q;
  assign frame_o = frame_q;
  assign busy_o  = (state_q == ST_START) || (state_q == ST_DATA) ||
                   (state_q == ST_STOP);

  AST_WAIT_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && state_q == ST_WAIT && !line_i) |=> (state_q == ST_WAIT)); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> (state_q == ST_WAIT && !done_q)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R3
  AST_BRK_NEEDS_LOW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && frame_q.brk) |-> (!frame_q.stop && frame_q.bits == '0)); // R5

endmodule

// File: rtl/uart_brk_status.sv
module uart_brk_status
  import uart_brk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  rx_frame_t     frame_i,
  input  logic          clr_i,
  output logic [DW-1:0] data_o,
  output logic          bit9_o,
  output logic          full_o,
  output logic          fe_o,
  output logic          ovr_o,
  output logic          brk_o
);

  logic [DW-1:0] data_q, data_d;
  logic          b9_q, b9_d;
  logic          full_q, full_d;
  logic          fe_q, fe_d;
  logic          ovr_q, ovr_d;
  logic          brk_q, brk_d;
  logic          still_full;

  assign still_full = full_q && !clr_i;

  always_comb begin
    data_d = data_q;
    b9_d   = b9_q;
    full_d = full_q;
    fe_d   = fe_q;
    ovr_d  = ovr_q;
    brk_d  = brk_q;
    if (clr_i) begin
      full_d = 1'b0;
      fe_d   = 1'b0;
      ovr_d  = 1'b0;
      brk_d  = 1'b0;
    end
    if (done_i) begin
      if (still_full) begin
        ovr_d = 1'b1;
        fe_d  = fe_q | !frame_i.stop;
        brk_d = brk_q | frame_i.brk;
      end else begin
        data_d = frame_i.brk ? '0 : frame_i.bits[DW-1:0];
        b9_d   = frame_i.brk ? 1'b0 : frame_i.bits[DW];
        full_d = 1'b1;
        fe_d   = !frame_i.stop;
        brk_d  = frame_i.brk;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      b9_q   <= 1'b0;
      full_q <= 1'b0;
      fe_q   <= 1'b0;
      ovr_q  <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      b9_q   <= b9_d;
      full_q <= full_d;
      fe_q   <= fe_d;
      ovr_q  <= ovr_d;
      brk_q  <= brk_d;
    end
  end

  assign data_o = data_q;
  assign bit9_o = b9_q;
  assign full_o = full_q;
  assign fe_o   = fe_q;
  assign ovr_o  = ovr_q;
  assign brk_o  = brk_q;

  AST_FULL_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> full_q); // R3
  AST_BRK_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && frame_i.brk && !still_full) |=> (data_q == '0 && !b9_q)); // R5
  AST_BRK_WITH_FE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |-> fe_q); // R5
  AST_OVR_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && still_full) |=> (ovr_q && $stable(data_q) && $stable(b9_q))); // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !done_i) |=> (!full_q && !fe_q && !ovr_q && !brk_q)); // R8

endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import uart_brk_pkg::*;
#(
  parameter int unsigned OVS        = 16,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          rx_line,
  input  logic          tick16,
  input  logic          nine_sel,
  input  logic          flag_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          rx_full,
  output logic          frame_err,
  output logic          overrun,
  output logic          brk_det,
  output logic          rx_busy
);

  logic      rst_sync_n;
  logic      line_s;
  logic      done;
  rx_frame_t frame;

  uart_brk_rstsync #(.STAGES(2)) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  uart_brk_insync #(.STAGES(SYNC_DEPTH)) u_insync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (rx_line),
    .dout  (line_s)
  );

  uart_brk_ctrl #(.OVS(OVS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_i    (rx_en),
    .tick_i  (tick16),
    .line_i  (line_s),
    .nine_i  (nine_sel),
    .done_o  (done),
    .frame_o (frame),
    .busy_o  (rx_busy)
  );

  uart_brk_status u_status (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .done_i  (done),
    .frame_i (frame),
    .clr_i   (flag_clr),
    .data_o  (rx_data),
    .bit9_o  (rx_bit9),
    .full_o  (rx_full),
    .fe_o    (frame_err),
    .ovr_o   (overrun),
    .brk_o   (brk_det)
  );

endmodule

// File: tb/uart_brk_rx_bench.sv
module uart_brk_rx_bench;

  localparam int BIT_CLKS = 64;
  localparam int NVEC     = 8;
  // {nine, payload[8:0], stop, exp_data[7:0], exp_b9, exp_fe, exp_brk}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 9'h0A5, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0},
    {1'b0, 9'h000, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b0, 9'h03C, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0},
    {1'b0, 9'h000, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},
    {1'b1, 9'h15A, 1'b1, 8'h5A, 1'b1, 1'b0, 1'b0},
    {1'b1, 9'h100, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0},
    {1'b1, 9'h000, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},
    {1'b0, 9'h0FF, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       rx_line = 1'b1;
  logic       nine_sel = 1'b0;
  logic       flag_clr = 1'b0;
  logic [1:0] div = '0;
  logic       tick16;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_full, frame_err, overrun, brk_det, rx_busy;
  int         checks = 0;
  int         failures = 0;
  int         cycles = 0;
  logic       finished = 1'b0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) div <= div + 2'd1;
  assign tick16 = (div == 2'd3);

  uart_brk_rx u_uart_brk_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_line(rx_line),
    .tick16(tick16), .nine_sel(nine_sel), .flag_clr(flag_clr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_full(rx_full),
    .frame_err(frame_err), .overrun(overrun), .brk_det(brk_det),
    .rx_busy(rx_busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rx_line = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic nine, input logic [8:0] pl, input logic stop);
    nine_sel = nine;
    drive_bit(1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) drive_bit(pl[i]);
    drive_bit(stop);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11: reset state
    chk("R11 data", int'(rx_data), 0);
    chk("R11 flags", int'({rx_full, frame_err, overrun, brk_det, rx_bit9}), 0);
    chk("R11 busy", int'(rx_busy), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rx_en = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);

    // Vector table: R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      pulse_clr();
      send_frame(VEC[v][21], VEC[v][20:12], VEC[v][11]);
      chk("R2/R3 data", int'(rx_data), int'(VEC[v][10:3]));
      chk("R2 bit9", int'(rx_bit9), int'(VEC[v][2]));
      chk("R4 frame_err", int'(frame_err), int'(VEC[v][1]));
      chk("R5 brk_det", int'(brk_det), int'(VEC[v][0]));
      chk("R3 full", int'(rx_full), 1);
      chk("R7 no overrun", int'(overrun), 0);
    end

    // R8: clear strobe clears flags, keeps data
    pulse_clr();
    chk("R8 flags cleared", int'({rx_full, frame_err, overrun, brk_det}), 0);
    chk("R8 data kept", int'(rx_data), 'hFF);

    // R1: glitch shorter than half a bit is rejected
    rx_line = 1'b0;
    repeat (16) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk("R1 false start full", int'(rx_full), 0);
    chk("R1 false start busy", int'(rx_busy), 0);

    // R9: busy during a character
    nine_sel = 1'b0;
    drive_bit(1'b0);
    drive_bit(1'b1);
    drive_bit(1'b0);
    chk("R9 busy mid frame", int'(rx_busy), 1);
    for (int i = 0; i < 6; i++) drive_bit(1'b1);
    drive_bit(1'b1);
    drive_bit(1'b1);
    drive_bit(1'b1);
    chk("R9 busy after stop", int'(rx_busy), 0);
    chk("R2 lsb first", int'(rx_data), 'hFD);

    // R7: overrun keeps older data
    pulse_clr();
    send_frame(1'b0, 9'h0A5, 1'b1);
    send_frame(1'b0, 9'h03C, 1'b1);
    chk("R7 overrun", int'(overrun), 1);
    chk("R7 data kept", int'(rx_data), 'hA5);
    chk("R7 fe clear", int'(frame_err), 0);

    // R7 with break: older data kept, break and fe still flagged
    pulse_clr();
    send_frame(1'b0, 9'h077, 1'b1);
    send_frame(1'b0, 9'h000, 1'b0);
    chk("R7 brk overrun", int'(overrun), 1);
    chk("R7 brk data kept", int'(rx_data), 'h77);
    chk("R5 brk flag on overrun", int'(brk_det), 1);
    chk("R5 fe on overrun", int'(frame_err), 1);

    // R6: line held low after break yields one character only
    pulse_clr();
    nine_sel = 1'b0;
    drive_bit(1'b0);
    for (int i = 0; i < 9; i++) drive_bit(1'b0);
    repeat (10) drive_bit(1'b0);
    chk("R5 break seen", int'(brk_det), 1);
    pulse_clr();
    repeat (10) drive_bit(1'b0);
    chk("R6 no new frame while low", int'(rx_full), 0);
    chk("R6 not busy while low", int'(rx_busy), 0);
    drive_bit(1'b1);
    drive_bit(1'b1);
    send_frame(1'b0, 9'h05A, 1'b1);
    chk("R6 recovers", int'(rx_data), 'h5A);
    chk("R6 recovers fe", int'(frame_err), 0);

    // R10: disabled receiver ignores traffic
    pulse_clr();
    rx_en = 1'b0;
    send_frame(1'b0, 9'h0C3, 1'b1);
    chk("R10 disabled full", int'(rx_full), 0);
    chk("R10 disabled data", int'(rx_data), 'h5A);
    rx_en = 1'b1;
    drive_bit(1'b1);
    send_frame(1'b0, 9'h011, 1'b1);
    chk("R10 re-enabled", int'(rx_data), 'h11);
    chk("R10 re-enabled full", int'(rx_full), 1);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule